// File: doc/BRIEF.md
# Bidirectional Mailbox Interrupt Unit

This block passes short messages between a host bus agent and a local processor through a shared set of registers. Inbound message registers are written by the host and read by the local processor. Outbound message registers are written by the local processor and read by the host. Every write of a message raises a sticky event bit in the status register of that direction. The receiving side acknowledges the event by writing a one to that bit.

Each direction has its own mask bit. An unmasked outbound event pulls one of four active-low host interrupt lines low, and a select register chooses which line. An unmasked inbound event drives a single active-high local interrupt.

Each side has a synchronous register port with a 3-bit word address, 32-bit write data, a write strobe, a read strobe and registered read data. Both ports use the same word map:

| Address | Host port | Local port |
|---|---|---|
| 0, 1 | inbound message 0/1 (write and read) | inbound message 0/1 (read only) |
| 2, 3 | outbound message 0/1 (read only) | outbound message 0/1 (write and read) |
| 4 | outbound status, bit 0, write one to clear | inbound status, bit 0, write one to clear |
| 5 | outbound mask, bit 0 | inbound mask, bit 0 |
| 6 | line select, bits 2:0 | reads 0 |
| 7 | reads 0 | reads 0 |

Top module: `mbx_unit`

## Requirements
- R1: A local write to address 2 or 3 stores the 32-bit word in that outbound message register and sets the outbound status bit (host address 4, bit 0) on the same clock edge.
- R2: A host write to address 0 or 1 stores the word in that inbound message register and sets the inbound status bit (local address 4, bit 0) on the same clock edge.
- R3: Writing 1 to bit 0 at address 4 clears that status bit. Writing 0 leaves it unchanged. The host clears the outbound bit and the local side clears the inbound bit.
- R4: When a message write and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R5: The mask bit at address 5 (1 = masked) blocks the interrupt of its direction while the status bit still records events. Clearing the mask with an event pending asserts the interrupt in the next cycle.
- R6: With the outbound interrupt active, the line select value 1, 2, 3 or 4 drives host_int_n bit 0, 1, 2 or 3 low, respectively. The value 0 (and the values 5 to 7) leaves all four lines high. At most one line is low at any time.
- R7: Every message register reads back on both ports. A write to it from the receiving side has no effect.
- R8: Read data appears the cycle after a read strobe and holds until the next strobe. Unused addresses read as 0.
- R9: After reset, all message registers, status bits, mask bits and the line select are 0, host_int_n is 4'b1111 and loc_irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 3 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_we | input | 1 | Host write strobe |
| h_re | input | 1 | Host read strobe |
| h_rdata | output | 32 | Host read data, registered |
| l_addr | input | 3 | Local word address |
| l_wdata | input | 32 | Local write data |
| l_we | input | 1 | Local write strobe |
| l_re | input | 1 | Local read strobe |
| l_rdata | output | 32 | Local read data, registered |
| host_int_n | output | 4 | Active-low host interrupt lines, bit 0 is the first line |
| loc_irq | output | 1 | Local interrupt, active high |

## Verification
The hardest case to reach from the ports is the cycle in which a message event and an acknowledge land on the same status bit. Reaching it takes both ports acting in one clock. The bench drives a host message write and a local write-one-to-clear on the same falling edge, then reads the status bit back.

Masked-then-unmasked events also need a set sequence: send a message while masked, confirm that the status bit is set and the line is quiet, then unmask and watch the line fall.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int NUM_MSG    = 2;
  localparam int NUM_LINES  = 4;
  localparam int SEL_W      = 3;
  localparam int IDX_W      = (NUM_MSG > 1) ? $clog2(NUM_MSG) : 1;

  localparam logic [ADDR_W-1:0] A_IN_BASE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUT_BASE = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS   = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK     = 3'd5;
  localparam logic [ADDR_W-1:0] A_LINESEL  = 3'd6;
endpackage

// File: rtl/mbx_dir.sv
module mbx_dir #(
  parameter int NUM_MSG = 2,
  parameter int DW      = 32,
  localparam int IW     = (NUM_MSG > 1) ? $clog2(NUM_MSG) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         snd_we,
  input  logic [IW-1:0]                snd_idx,
  input  logic [DW-1:0]                snd_wdata,
  input  logic                         clr_we,
  input  logic                         clr_one,
  input  logic                         mask_we,
  input  logic                         mask_val,
  output logic [NUM_MSG-1:0][DW-1:0]   msg_q,
  output logic                         status_q,
  output logic                         mask_q,
  output logic                         irq
);
  logic status_d;
  logic mask_d;

  for (genvar g = 0; g < NUM_MSG; g++) begin : g_msg
    logic          en;
    logic [DW-1:0] d;
    always_comb begin
      en = snd_we && (snd_idx == IW'(g));
      d  = snd_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  msg_q[g] <= '0;
      else if (en) msg_q[g] <= d;
    end
  end

  always_comb begin
    status_d = status_q;
    if (clr_we && clr_one) status_d = 1'b0;
    if (snd_we)            status_d = 1'b1;
    mask_d = mask_we ? mask_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign irq = status_q && !mask_q;

  AST_SEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    snd_we |=> status_q); // R1
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_one && !snd_we) |=> !status_q); // R3
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !(clr_we && clr_one)) |=> status_q); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_we && clr_we && clr_one) |=> status_q); // R4
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_we |=> $stable(msg_q)); // R7
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_val) |=> !irq); // R5
endmodule

// File: rtl/mbx_pin_route.sv
module mbx_pin_route #(
  parameter int NUM_LINES = 4,
  parameter int SEL_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq,
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_LINES-1:0] lines_n
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign lines_n[g] = !(irq && (sel == SEL_W'(g + 1)));
  end

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~lines_n)); // R6
  AST_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (&lines_n)); // R6
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (&lines_n)); // R6
endmodule

// File: rtl/mbx_unit.sv
module mbx_unit
  import mbx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    h_addr,
  input  logic [DATA_W-1:0]    h_wdata,
  input  logic                 h_we,
  input  logic                 h_re,
  output logic [DATA_W-1:0]    h_rdata,
  input  logic [ADDR_W-1:0]    l_addr,
  input  logic [DATA_W-1:0]    l_wdata,
  input  logic                 l_we,
  input  logic                 l_re,
  output logic [DATA_W-1:0]    l_rdata,
  output logic [NUM_LINES-1:0] host_int_n,
  output logic                 loc_irq
);
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [ADDR_W-1:0] h_in_off, l_out_off;
  logic              h_in_hit, l_out_hit;
  always_comb begin
    h_in_off  = h_addr - A_IN_BASE;
    l_out_off = l_addr - A_OUT_BASE;
    h_in_hit  = h_addr >= A_IN_BASE  && h_addr < A_IN_BASE  + ADDR_W'(NUM_MSG);
    l_out_hit = l_addr >= A_OUT_BASE && l_addr < A_OUT_BASE + ADDR_W'(NUM_MSG);
  end

  logic [NUM_MSG-1:0][DATA_W-1:0] in_msg, out_msg;
  logic in_stat, in_mask, in_irq;
  logic out_stat, out_mask, out_irq;

  mbx_dir #(.NUM_MSG(NUM_MSG), .DW(DATA_W)) u_inbound (
    .clk, .rst_n(rst_q_n),
    .snd_we(h_we && h_in_hit), .snd_idx(h_in_off[IDX_W-1:0]), .snd_wdata(h_wdata),
    .clr_we(l_we && l_addr == A_STATUS), .clr_one(l_wdata[0]),
    .mask_we(l_we && l_addr == A_MASK), .mask_val(l_wdata[0]),
    .msg_q(in_msg), .status_q(in_stat), .mask_q(in_mask), .irq(in_irq)
  );

  mbx_dir #(.NUM_MSG(NUM_MSG), .DW(DATA_W)) u_outbound (
    .clk, .rst_n(rst_q_n),
    .snd_we(l_we && l_out_hit), .snd_idx(l_out_off[IDX_W-1:0]), .snd_wdata(l_wdata),
    .clr_we(h_we && h_addr == A_STATUS), .clr_one(h_wdata[0]),
    .mask_we(h_we && h_addr == A_MASK), .mask_val(h_wdata[0]),
    .msg_q(out_msg), .status_q(out_stat), .mask_q(out_mask), .irq(out_irq)
  );

  logic [SEL_W-1:0] sel_q, sel_d;
  always_comb sel_d = (h_we && h_addr == A_LINESEL) ? h_wdata[SEL_W-1:0] : sel_q;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) sel_q <= '0;
    else          sel_q <= sel_d;
  end

  mbx_pin_route #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_route (
    .clk, .rst_n(rst_q_n), .irq(out_irq), .sel(sel_q), .lines_n(host_int_n)
  );
  assign loc_irq = in_irq;

  // Read side: one shared view of the message registers, per-port control words
  function automatic logic [DATA_W-1:0] msg_view(input logic [ADDR_W-1:0] a,
      input logic [NUM_MSG-1:0][DATA_W-1:0] im, input logic [NUM_MSG-1:0][DATA_W-1:0] om);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_MSG; k++) begin
      if (a == A_IN_BASE  + ADDR_W'(k)) v = im[k];
      if (a == A_OUT_BASE + ADDR_W'(k)) v = om[k];
    end
    return v;
  endfunction

  logic [DATA_W-1:0] h_rd_d, l_rd_d;
  always_comb begin
    h_rd_d = msg_view(h_addr, in_msg, out_msg);
    case (h_addr)
      A_STATUS:  h_rd_d = DATA_W'(out_stat);
      A_MASK:    h_rd_d = DATA_W'(out_mask);
      A_LINESEL: h_rd_d = DATA_W'(sel_q);
      default:   ;
    endcase
    l_rd_d = msg_view(l_addr, in_msg, out_msg);
    case (l_addr)
      A_STATUS: l_rd_d = DATA_W'(in_stat);
      A_MASK:   l_rd_d = DATA_W'(in_mask);
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      h_rdata <= '0;
      l_rdata <= '0;
    end else begin
      if (h_re) h_rdata <= h_rd_d;
      if (l_re) l_rdata <= l_rd_d;
    end
  end

  AST_HRD_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !h_re |=> $stable(h_rdata)); // R8
  AST_LRD_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !l_re |=> $stable(l_rdata)); // R8
  AST_INB_SET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (h_we && h_in_hit && !in_mask) |=> loc_irq); // R2
endmodule

// File: tb/mbx_unit_tb_top.sv
module mbx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  h_addr = '0, l_addr = '0;
  logic [31:0] h_wdata = '0, l_wdata = '0;
  logic        h_we = 1'b0, h_re = 1'b0, l_we = 1'b0, l_re = 1'b0;
  logic [31:0] h_rdata, l_rdata;
  logic [3:0]  host_int_n;
  logic        loc_irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mbx_unit dut_i (.clk, .rst_n, .h_addr, .h_wdata, .h_we, .h_re, .h_rdata,
    .l_addr, .l_wdata, .l_we, .l_re, .l_rdata, .host_int_n, .loc_irq);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // side 1=host 0=local ; wr 1=write 0=read+compare
  localparam int NV = 20;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 32'h0,          32'h0},          // R9 inbound msg reset
    {1'b0, 1'b0, 3'd5, 32'h0,          32'h0},          // R9 inbound mask reset
    {1'b1, 1'b1, 3'd0, 32'hA5A5_0001,  32'h0},
    {1'b0, 1'b0, 3'd0, 32'h0,          32'hA5A5_0001},  // R2 data
    {1'b0, 1'b0, 3'd4, 32'h0,          32'h1},          // R2 status
    {1'b0, 1'b1, 3'd4, 32'h0,          32'h0},
    {1'b0, 1'b0, 3'd4, 32'h0,          32'h1},          // R3 zero keeps
    {1'b0, 1'b1, 3'd4, 32'h1,          32'h0},
    {1'b0, 1'b0, 3'd4, 32'h0,          32'h0},          // R3 one clears
    {1'b0, 1'b1, 3'd2, 32'h1234_5678,  32'h0},
    {1'b1, 1'b0, 3'd2, 32'h0,          32'h1234_5678},  // R1 data
    {1'b1, 1'b0, 3'd4, 32'h0,          32'h1},          // R1 status
    {1'b1, 1'b1, 3'd2, 32'hFFFF_FFFF,  32'h0},
    {1'b1, 1'b0, 3'd2, 32'h0,          32'h1234_5678},  // R7 ignored
    {1'b0, 1'b1, 3'd0, 32'hDEAD_BEEF,  32'h0},
    {1'b1, 1'b0, 3'd0, 32'h0,          32'hA5A5_0001},  // R7 ignored
    {1'b1, 1'b1, 3'd4, 32'h1,          32'h0},
    {1'b1, 1'b0, 3'd4, 32'h0,          32'h0},          // R3 host clears
    {1'b1, 1'b1, 3'd6, 32'h3,          32'h0},
    {1'b1, 1'b0, 3'd7, 32'h0,          32'h0}           // R8 unused
  };

  task automatic hwr(input logic [2:0] a, input logic [31:0] d);
    h_addr = a; h_wdata = d; h_we = 1'b1;
    @(negedge clk); h_we = 1'b0;
  endtask
  task automatic lwr(input logic [2:0] a, input logic [31:0] d);
    l_addr = a; l_wdata = d; l_we = 1'b1;
    @(negedge clk); l_we = 1'b0;
  endtask
  task automatic hrd(input logic [2:0] a, output logic [31:0] d);
    h_addr = a; h_re = 1'b1;
    @(negedge clk); h_re = 1'b0; d = h_rdata;
  endtask
  task automatic lrd(input logic [2:0] a, output logic [31:0] d);
    l_addr = a; l_re = 1'b1;
    @(negedge clk); l_re = 1'b0; d = l_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    @(negedge clk);
    do_reset();
    chk("R9 lines", 32'(host_int_n), 32'hF);
    chk("R9 loc_irq", 32'(loc_irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [68:0] v;
      v = VEC[i];
      if (v[67]) begin
        if (v[68]) hwr(v[66:64], v[63:32]); else lwr(v[66:64], v[63:32]);
      end else begin
        if (v[68]) hrd(v[66:64], rd); else lrd(v[66:64], rd);
        chk($sformatf("R1-R9 table row %0d", i), rd, v[31:0]);
      end
    end

    // R8: read data holds without a strobe
    h_addr = 3'd2; @(negedge clk);
    chk("R8 hold", h_rdata, 32'h0);

    // R6: select 3 drives third line
    lwr(3'd3, 32'hCAFE_0003);
    chk("R6 sel3", 32'(host_int_n), 32'b1011);
    lrd(3'd3, rd);
    chk("R7 local readback", rd, 32'hCAFE_0003);
    // R5 mask: status kept, line quiet
    hwr(3'd5, 32'h1);
    chk("R5 masked", 32'(host_int_n), 32'hF);
    hrd(3'd4, rd);
    chk("R5 status kept", rd, 32'h1);
    hwr(3'd5, 32'h0);
    chk("R5 unmask", 32'(host_int_n), 32'b1011);
    hwr(3'd6, 32'h0);
    chk("R6 sel0", 32'(host_int_n), 32'hF);
    hwr(3'd6, 32'h1);
    chk("R6 sel1", 32'(host_int_n), 32'b1110);
    hwr(3'd6, 32'h4);
    chk("R6 sel4", 32'(host_int_n), 32'b0111);
    hwr(3'd6, 32'h5);
    chk("R6 sel5", 32'(host_int_n), 32'hF);
    hwr(3'd6, 32'h2);
    hwr(3'd4, 32'h1);
    chk("R3 cleared lines", 32'(host_int_n), 32'hF);

    // R2/R5 inbound interrupt
    hwr(3'd1, 32'h0000_0B0B);
    chk("R2 loc_irq", 32'(loc_irq), 32'h1);
    lwr(3'd5, 32'h1);
    chk("R5 inbound masked", 32'(loc_irq), 32'h0);
    lwr(3'd5, 32'h0);
    chk("R5 inbound unmask", 32'(loc_irq), 32'h1);
    lwr(3'd4, 32'h1);
    chk("R3 inbound cleared", 32'(loc_irq), 32'h0);

    // R4: message event and acknowledge in the same cycle
    h_addr = 3'd0; h_wdata = 32'h4444_0000; h_we = 1'b1;
    l_addr = 3'd4; l_wdata = 32'h1;         l_we = 1'b1;
    @(negedge clk); h_we = 1'b0; l_we = 1'b0;
    chk("R4 set wins irq", 32'(loc_irq), 32'h1);
    lrd(3'd4, rd);
    chk("R4 set wins status", rd, 32'h1);

    // R9 reset mid-run
    hwr(3'd5, 32'h1);
    lwr(3'd2, 32'h7);
    do_reset();
    chk("R9 lines after", 32'(host_int_n), 32'hF);
    chk("R9 irq after", 32'(loc_irq), 32'h0);
    hrd(3'd5, rd); chk("R9 mask", rd, 32'h0);
    hrd(3'd6, rd); chk("R9 sel", rd, 32'h0);
    lrd(3'd2, rd); chk("R9 msg", rd, 32'h0);
    lrd(3'd4, rd); chk("R9 status", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule